// File: doc/BRIEF.md
# OFDM Cyclic Prefix Extender

This block sits between an inverse FFT and a digital-to-analog path. It receives the time-domain samples of one OFDM symbol, 64 complex pairs in natural index order, and sends out an 81-pair extended symbol. The extended symbol starts with a guard prefix that copies the 16 final samples. The complete 64-sample body follows. A single repeat of sample 0 closes the symbol.

Both sides are valid/ready streams that carry one pair per transfer: 16-bit signed real (I) and 16-bit signed imaginary (Q). Two symbol buffers sit inside the block. While one symbol is being emitted, the next one can be loaded, so back-to-back symbols move without a gap on the input side. The output flags the closing sample of each extended symbol.

Top module: `cp_extender`

## Requirements
- R1: After reset, m_valid and m_last are 0 and s_ready is 1.
- R2: Each symbol of 64 accepted input pairs yields exactly 81 output pairs. Output positions 0 to 15 carry input indices 48 to 63, in ascending order.
- R3: Output positions 16 to 79 carry input indices 0 to 63, in ascending order and unchanged.
- R4: Output position 80 carries input index 0 again.
- R5: m_last is 1 on output position 80 and 0 on every other position.
- R6: m_last is never 1 while m_valid is 0.
- R7: While m_valid is 1 and m_ready is 0, m_valid, m_re, m_im and m_last keep their values into the next cycle.
- R8: A second symbol can be fully accepted before any output is taken. Once two whole symbols are buffered, s_ready is 0, and input offered at that time changes neither buffered symbol.
- R9: Symbols leave the block in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input pair offered |
| s_ready | output | 1 | Input pair can be taken |
| s_re | input | 16 | Input real part, signed |
| s_im | input | 16 | Input imaginary part, signed |
| m_valid | output | 1 | Output pair offered |
| m_ready | input | 1 | Downstream takes the output pair |
| m_re | output | 16 | Output real part, signed |
| m_im | output | 16 | Output imaginary part, signed |
| m_last | output | 1 | Final pair of an extended symbol |

## Verification
On every cycle, assertions check three stream rules: the output is held steady under backpressure, the last flag appears only with valid data and never twice in a row after it is taken, and the block comes out of reset idle. The actual sample ordering needs the bench scenarios to show it. These cover the prefix taken from the tail, the unchanged body, the trailing repeat, and the emission order of queued symbols. The bench scenarios also show that input offered while both buffers are full is ignored.

// File: rtl/cp_extender.sv
module cp_extender #(
  parameter int W  = 16,
  parameter int N  = 64,
  parameter int CP = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_re,
  input  logic [W-1:0] s_im,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_re,
  output logic [W-1:0] m_im,
  output logic         m_last
);
  localparam int TOTAL = N + CP + 1;
  localparam int AW = $clog2(N);
  localparam int CW = $clog2(TOTAL);

  logic [2*W-1:0] mem [2][N];
  logic [1:0]     full;
  logic           wr_bank, rd_bank;
  logic [AW-1:0]  wr_cnt, rd_idx;
  logic [CW-1:0]  rd_cnt;

  wire wr_fire = s_valid && s_ready;
  wire rd_fire = m_valid && m_ready;
  wire wr_end  = wr_cnt == AW'(N - 1);
  wire rd_end  = rd_cnt == CW'(TOTAL - 1);

  assign s_ready = !full[wr_bank];
  assign m_valid = full[rd_bank];
  assign m_last  = m_valid && rd_end;

  always_comb begin
    if (rd_cnt < CW'(CP))
      rd_idx = AW'(N - CP) + rd_cnt[AW-1:0];
    else if (rd_cnt < CW'(CP + N))
      rd_idx = AW'(rd_cnt - CW'(CP));
    else
      rd_idx = '0;
  end

  assign {m_re, m_im} = mem[rd_bank][rd_idx];

  always_ff @(posedge clk)
    if (wr_fire) mem[wr_bank][wr_cnt] <= {s_re, s_im};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= '0;
      wr_bank <= 1'b0;
      rd_bank <= 1'b0;
      wr_cnt  <= '0;
      rd_cnt  <= '0;
    end else begin
      if (wr_fire) begin
        wr_cnt <= wr_cnt + 1'b1;
        if (wr_end) begin
          full[wr_bank] <= 1'b1;
          wr_bank       <= !wr_bank;
        end
      end
      if (rd_fire) begin
        if (rd_end) begin
          rd_cnt        <= '0;
          full[rd_bank] <= 1'b0;
          rd_bank       <= !rd_bank;
        end else begin
          rd_cnt <= rd_cnt + 1'b1;
        end
      end
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !m_valid && !m_last && s_ready);

  a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid);

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid && $stable(m_re) && $stable(m_im) && $stable(m_last));

  a_r5_last_not_repeated: assert property (@(posedge clk) disable iff (!rst_n)
    (m_last && m_ready) |=> !m_last);
endmodule

// File: tb/cp_extender_tb.sv
module cp_extender_tb_top;
  logic clk = 0, rst_n = 0;
  logic s_valid = 0, m_ready = 0;
  logic [15:0] s_re = 0, s_im = 0;
  logic s_ready, m_valid, m_last;
  logic [15:0] m_re, m_im;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = !clk;

  cp_extender dut_i (.clk, .rst_n, .s_valid, .s_ready, .s_re, .s_im,
                     .m_valid, .m_ready, .m_re, .m_im, .m_last);

  // {stall, base_re, step_re, base_im, xor_step_im}
  localparam logic [64:0] VEC [0:3] = '{
    {1'b0, 16'h0000, 16'h0001, 16'h8000, 16'h0101},
    {1'b0, 16'h7FF0, 16'h0103, 16'h1234, 16'h0F0F},
    {1'b1, 16'hA57E, 16'hFFF9, 16'h5A82, 16'h0011},
    {1'b1, 16'h8692, 16'h0040, 16'h796E, 16'h2222}
  };

  function automatic logic [31:0] sample(int v, int k);
    logic [64:0] e = VEC[v];
    logic [15:0] re = e[63:48] + e[47:32] * 16'(k);
    logic [15:0] im = e[31:16] ^ (e[15:0] * 16'(k + 1));
    return {re, im};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(int v);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      s_valid = 1;
      {s_re, s_im} = sample(v, k);
      while (!s_ready) @(negedge clk);
    end
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic recv(int v, bit stall);
    for (int p = 0; p < 81; p++) begin
      int k;
      logic [31:0] exp;
      @(negedge clk);
      m_ready = !(stall && (p % 3 == 0));
      if (m_valid && !m_ready) begin
        logic [32:0] held = {m_last, m_re, m_im};
        @(negedge clk);
        check(m_valid && {m_last, m_re, m_im} == held, "R7 hold", 64'({m_last, m_re, m_im}), 64'(held));
        m_ready = 1;
      end
      m_ready = 1;
      while (!m_valid) @(negedge clk);
      k = (p < 16) ? 48 + p : (p < 80) ? p - 16 : 0;
      exp = sample(v, k);
      check({m_re, m_im} == exp,
            (p < 16) ? "R2 prefix" : (p < 80) ? "R3 body" : "R4 trailing repeat / R9 order",
            64'({m_re, m_im}), 64'(exp));
      check(m_last == (p == 80), "R5 last flag", 64'(m_last), 64'(p == 80));
    end
    @(negedge clk);
    m_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!m_valid && !m_last && s_ready, "R1 reset state",
          64'({m_valid, m_last, s_ready}), 64'(3'b001));
    rst_n = 1;

    // table walk: stream each symbol while reading it out
    for (int v = 0; v < 4; v++) begin
      fork
        send(v);
        recv(v, VEC[v][64]);
      join
    end

    // two symbols queued with no reads (R8), then ordered drain (R9)
    send(0);
    send(1);
    check(!s_ready, "R8 both buffers full", 64'(s_ready), 64'(0));
    check(!m_last || m_valid, "R6 last only with valid", 64'(m_last), 64'(0));
    @(negedge clk);
    s_valid = 1; s_re = 16'hDEAD; s_im = 16'hBEEF;
    repeat (5) @(negedge clk);
    check(!s_ready, "R8 input refused while full", 64'(s_ready), 64'(0));
    s_valid = 0;
    recv(0, 0);
    check(s_ready, "R8 buffer freed", 64'(s_ready), 64'(1));
    recv(1, 1);
    @(negedge clk);
    check(!m_valid && !m_last, "R6 idle after drain", 64'({m_valid, m_last}), 64'(0));

    // queue next symbol while previous one still being emitted
    fork
      begin send(2); send(3); end
      begin recv(2, 1); recv(3, 0); end
    join

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule